// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block drives a JTAG test access port from the host side of a chip. It generates TCK, TMS and TDI, samples TDO, and takes one command at a time over a valid/ready port. A command either resets the TAP, walks it from Run-Test/Idle (or from an Update state) into Shift-IR or Shift-DR, or shifts a word of 1 to `DATA_W` bits. When a command finishes, a single-cycle done strobe comes out with the captured TDO word.

Each shift command carries three flags. The first sets the bit order. The second says whether the final data bit leaves the shift state or keeps the scan open, so that several commands can build one long scan. The third says whether an ended scan stops in Update or goes on to Run-Test/Idle. The TCK half-period is `half_div + 1` system clocks, and TCK rests high between commands.

Top module: `jtag_master`

## Requirements
- R1: While idle and after reset, `cmd_ready` is high, TCK and TDI are high and `done` is low. TMS is high straight after reset.
- R2: Opcode 0 (TAP reset) produces six TCK cycles with TMS = 1,1,1,1,1,0, which leaves the TAP in Run-Test/Idle.
- R3: Opcode 1 produces TMS = 1,1,0,0 and ends in Shift-IR. Opcode 2 produces TMS = 1,0,0 and ends in Shift-DR. Both sequences work from Run-Test/Idle and from either Update state.
- R4: Opcode 3 with `cmd_msb`=0 drives `cmd_data` bit 0 first. The k-th TDO bit captured lands in `rdata` bit k, and `rdata` bits at `cmd_len` and above read 0.
- R5: With `cmd_msb`=1, bit `cmd_len`-1 is driven first, data bits at `cmd_len` and above are ignored, and the k-th captured TDO bit lands in `rdata` bit `cmd_len`-1-k.
- R6: With `cmd_end`=1, TMS is high only on the last data bit. With `cmd_end`=0, TMS is low on every data bit and the TAP stays in the shift state.
- R7: An ended shift adds one TCK with TMS high (Exit to Update). If `cmd_idle`=1 it also adds one TCK with TMS low (to Run-Test/Idle). `cmd_idle` has no effect when `cmd_end`=0.
- R8: After a shift with `cmd_end`=0, an opcode 1 or 2 command completes with `done` and produces no TCK cycle. The next shift command continues the same scan.
- R9: Each TCK low and high phase lasts `half_div`+1 system clocks. TMS and TDI change only on the clock in which TCK falls. TDO is sampled as TCK rises.
- R10: A command is accepted only while `cmd_ready` is high. `cmd_ready` stays low until the command completes. `done` pulses once per command together with `rdata`, which reads 0 for opcodes 0 to 2.
- R11: Shift lengths 1 and `DATA_W` work like any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | TCK half-period minus one, in system clocks; hold stable during a command |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 TAP reset, 1 go to Shift-IR, 2 go to Shift-DR, 3 shift |
| cmd_len | input | $clog2(DATA_W+1) | Shift length, 1 to DATA_W |
| cmd_data | input | DATA_W | Word to shift out on TDI |
| cmd_msb | input | 1 | 1: most significant bit first |
| cmd_end | input | 1 | 1: leave the shift state on the last bit |
| cmd_idle | input | 1 | 1: after Update, go on to Run-Test/Idle |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W | Captured TDO word |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench builds the block with `DATA_W` = 32 and `DIV_W` = 8. This makes both the longest shift (32 bits, 34 TCK cycles) and the single-bit shift reachable. Most runs use `half_div` = 0, which keeps every scan to a few clocks per bit. One run sets `half_div` = 3 to check the phase widths. A TAP state model in the bench follows every TCK edge, so the state the TAP ends in (Run-Test/Idle, Shift, Update) is checked for every command and every flag combination.

// File: rtl/jtag_master.sv
module jtag_master #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1),
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int TIK_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_msb,
  input  logic              cmd_end,
  input  logic              cmd_idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);

  localparam logic [1:0] OP_RESET = 2'd0;
  localparam logic [1:0] OP_IR    = 2'd1;
  localparam logic [1:0] OP_DR    = 2'd2;
  localparam logic [1:0] OP_SHIFT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_START, S_LOW, S_HIGH} state_t;

  state_t            st;
  logic [1:0]        op_q;
  logic [LEN_W-1:0]  len_q;
  logic              msb_q, end_q, mid_scan;
  logic [DATA_W-1:0] sreg, mask_q, mask_in, cap_lsb, cap_msb;
  logic [5:0]        nav_q, nav_in, nav_sel;
  logic [TIK_W-1:0]  idx, nidx, last_q, last_in, len_t;
  logic [DIV_W-1:0]  div_q, dcnt;
  logic [IDX_W-1:0]  top_idx;
  logic              tck_q, tms_q, tdi_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              shifting, nav_cmd, tms_n, tdi_n, data_tick;

  assign cmd_ready = (st == S_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = tdi_q;

  assign shifting  = (op_q == OP_SHIFT);
  assign nav_cmd   = (cmd_op == OP_IR) || (cmd_op == OP_DR);
  assign len_t     = TIK_W'(len_q);
  assign top_idx   = IDX_W'(len_q - 1'b1);
  assign nidx      = (st == S_START) ? '0 : idx + TIK_W'(1);
  assign nav_sel   = nav_q >> nidx;
  assign data_tick = shifting && (idx < len_t);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask_in[i] = (i < int'(cmd_len));
  end

  always_comb begin
    case (cmd_op)
      OP_RESET: begin nav_in = 6'b011111; last_in = TIK_W'(5); end
      OP_IR:    begin nav_in = 6'b000011; last_in = TIK_W'(3); end
      OP_DR:    begin nav_in = 6'b000001; last_in = TIK_W'(2); end
      default: begin
        nav_in  = 6'b000000;
        last_in = TIK_W'(cmd_len) - TIK_W'(1) + TIK_W'(cmd_end)
                + TIK_W'(cmd_end & cmd_idle);
      end
    endcase
  end

  always_comb begin
    if (!shifting)             tms_n = nav_sel[0];
    else if (nidx < len_t)     tms_n = end_q && (nidx == len_t - TIK_W'(1));
    else                       tms_n = (nidx == len_t);
  end

  always_comb begin
    if (shifting && (nidx < len_t)) tdi_n = msb_q ? sreg[top_idx] : sreg[0];
    else                            tdi_n = 1'b1;
  end

  always_comb begin
    cap_lsb          = sreg >> 1;
    cap_lsb[top_idx] = tdo;
    cap_msb          = ((sreg << 1) | DATA_W'(tdo)) & mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_RESET;
      len_q    <= '0;
      msb_q    <= 1'b0;
      end_q    <= 1'b0;
      mid_scan <= 1'b0;
      sreg     <= '0;
      mask_q   <= '0;
      nav_q    <= '0;
      idx      <= '0;
      last_q   <= '0;
      div_q    <= '0;
      dcnt     <= '0;
      tck_q    <= 1'b1;
      tms_q    <= 1'b1;
      tdi_q    <= 1'b1;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (nav_cmd && mid_scan) begin
            done_q  <= 1'b1;
            rdata_q <= '0;
          end else begin
            op_q   <= cmd_op;
            len_q  <= cmd_len;
            msb_q  <= cmd_msb;
            end_q  <= cmd_end;
            sreg   <= cmd_data & mask_in;
            mask_q <= mask_in;
            nav_q  <= nav_in;
            last_q <= last_in;
            div_q  <= half_div;
            idx    <= '0;
            st     <= S_START;
          end
        end
        S_START: begin
          idx   <= nidx;
          tms_q <= tms_n;
          tdi_q <= tdi_n;
          tck_q <= 1'b0;
          dcnt  <= div_q;
          st    <= S_LOW;
        end
        S_LOW: begin
          if (dcnt == '0) begin
            tck_q <= 1'b1;
            dcnt  <= div_q;
            st    <= S_HIGH;
            if (data_tick) sreg <= msb_q ? cap_msb : cap_lsb;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (dcnt != '0) begin
            dcnt <= dcnt - 1'b1;
          end else if (idx == last_q) begin
            st       <= S_IDLE;
            done_q   <= 1'b1;
            rdata_q  <= shifting ? sreg : '0;
            tdi_q    <= 1'b1;
            mid_scan <= shifting && !end_q;
          end else begin
            idx   <= nidx;
            tms_q <= tms_n;
            tdi_q <= tdi_n;
            tck_q <= 1'b0;
            dcnt  <= div_q;
            st    <= S_LOW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/jtag_master_check.sv
module jtag_master_check #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             cmd_ready,
  input logic             done,
  input logic             tck,
  input logic             tms,
  input logic             tdi
);

  logic [DIV_W:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || tck) lo_cnt <= '0;
    else               lo_cnt <= lo_cnt + 1'b1;
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (tck && tdi));

  assert_busy_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tck |-> !cmd_ready);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));

  assert_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck) && !cmd_ready) |-> ($stable(tms) && $stable(tdi)));

  assert_low_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && !$past(tck)) |-> (lo_cnt == {1'b0, half_div} + 1'b1));

endmodule

bind jtag_master jtag_master_check #(.DIV_W(DIV_W)) u_check (
  .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_ready(cmd_ready),
  .done(done), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/jtag_master_test.sv
module jtag_master_test;
  localparam int DW = 32;
  localparam int LW = $clog2(DW + 1);

  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PSDR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PSIR = 13, EX2IR = 14, UPIR = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] half_div = 8'd0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_msb = 1'b0, cmd_end = 1'b0, cmd_idle = 1'b0;
  logic done, tck, tms, tdi;
  logic tdo = 1'b0;
  logic [DW-1:0] rdata;

  jtag_master #(.DATA_W(DW), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .cmd_msb(cmd_msb), .cmd_end(cmd_end),
    .cmd_idle(cmd_idle), .done(done), .rdata(rdata), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  int rec_n = 0, base = 0, done_cnt = 0;
  int tap = TLR;
  logic rec_tms [0:1023];
  logic rec_tdi [0:1023];
  logic [63:0] tdo_pat = '0;
  logic prev_tck = 1'b1;
  int run = 0, lo_last = 0, hi_last = 0;

  function automatic int tap_next(int s, logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PSDR;
      PSDR:  return m ? EX2DR : PSDR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PSIR;
      PSIR:  return m ? EX2IR : PSIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    rec_tms[rec_n & 1023] = tms;
    rec_tdi[rec_n & 1023] = tdi;
    tap = tap_next(tap, tms);
    rec_n = rec_n + 1;
  end

  always @(negedge tck) tdo <= tdo_pat[(rec_n - base) & 63];

  always @(negedge clk) begin
    if (done) done_cnt = done_cnt + 1;
    if (tck == prev_tck) run = run + 1;
    else begin
      if (prev_tck) hi_last = run; else lo_last = run;
      run = 1;
    end
    prev_tck = tck;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [DW-1:0] data,
                      input int len, input bit msb, input bit en, input bit idl,
                      input bit hold, output logic [DW-1:0] rd, output int nt,
                      output bit busy_seen);
    int d0;
    base = rec_n;
    d0 = done_cnt;
    busy_seen = 1'b0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data; cmd_len = LW'(len);
    cmd_msb = msb; cmd_end = en; cmd_idle = idl;
    @(negedge clk);
    if (hold) cmd_op = 2'd0; else cmd_valid = 1'b0;
    if (!cmd_ready) busy_seen = 1'b1;
    while (!done) @(negedge clk);
    cmd_valid = 1'b0;
    rd = rdata;
    nt = rec_n - base;
    @(negedge clk);
    chk(done_cnt - d0 == 1, "R10", "done pulses", 64'(done_cnt - d0), 1);
    chk(tck && tdi && cmd_ready, "R1", "idle lines after command",
        {61'd0, tck, tdi, cmd_ready}, 64'd7);
  endtask

  task automatic nav(input logic [1:0] op, input int exp_tap, input string req);
    logic [DW-1:0] rd; int nt; bit b;
    logic [5:0] seq; int n;
    send(op, '0, 1, 0, 0, 0, 0, rd, nt, b);
    if (op == 2'd0) begin seq = 6'b011111; n = 6; end
    else if (op == 2'd1) begin seq = 6'b000011; n = 4; end
    else begin seq = 6'b000001; n = 3; end
    chk(nt == n, req, "tick count", 64'(nt), 64'(n));
    for (int i = 0; i < n && i < nt; i++)
      chk(rec_tms[(base + i) & 1023] == seq[i], req, "tms bit", 64'(i), 64'(seq[i]));
    chk(tap == exp_tap, req, "tap state", 64'(tap), 64'(exp_tap));
    chk(rd == '0, "R10", "rdata zero for navigation", 64'(rd), 0);
  endtask

  task automatic shift(input logic [DW-1:0] data, input int len, input bit msb,
                       input bit en, input bit idl, input logic [63:0] pat,
                       input int exp_tap, input string req, input bit hold);
    logic [DW-1:0] rd, exp; int nt, n; bit b;
    logic [3:0] etms;
    tdo_pat = pat;
    send(2'd3, data, len, msb, en, idl, hold, rd, nt, b);
    n = len + (en ? 1 : 0) + ((en && idl) ? 1 : 0);
    chk(nt == n, "R7", "tick count", 64'(nt), 64'(n));
    exp = '0;
    for (int i = 0; i < len; i++) begin
      logic eb;
      eb = msb ? data[len-1-i] : data[i];
      chk(rec_tdi[(base + i) & 1023] == eb, msb ? "R5" : "R4", "tdi bit",
          64'(i), 64'(eb));
      chk(rec_tms[(base + i) & 1023] == (en && i == len - 1), "R6", "tms on data bit",
          64'(rec_tms[(base + i) & 1023]), 64'(en && i == len - 1));
      if (msb) exp[len-1-i] = pat[i]; else exp[i] = pat[i];
    end
    etms = 4'b0001;
    for (int i = len; i < n; i++)
      chk(rec_tms[(base + i) & 1023] == etms[i - len], "R7", "tms trailing",
          64'(rec_tms[(base + i) & 1023]), 64'(etms[i - len]));
    chk(rd == exp, req, "captured word", 64'(rd), 64'(exp));
    chk(tap == exp_tap, req, "tap state", 64'(tap), 64'(exp_tap));
    if (hold) chk(b, "R10", "ready low while busy", 64'(b), 1);
  endtask

  task automatic t_reset_state;
    chk(cmd_ready && tck && tms && tdi && !done, "R1", "reset state",
        {59'd0, cmd_ready, tck, tms, tdi, done}, 64'h1E);
  endtask

  task automatic t_tap_reset;
    nav(2'd0, RTI, "R2");
  endtask

  task automatic t_ir_lsb;
    nav(2'd1, SHIR, "R3");
    shift(32'h0000000A, 4, 0, 1, 1, 64'h6, RTI, "R4", 0);
  endtask

  task automatic t_dr_full;
    nav(2'd2, SHDR, "R3");
    shift(32'h89ABCDEF, 32, 0, 1, 1, 64'h1234_5678_C3A5_0F96, RTI, "R11", 0);
  endtask

  task automatic t_msb_update;
    nav(2'd2, SHDR, "R3");
    shift(32'hFFFF_FFC5, 8, 1, 1, 0, 64'h35, UPDR, "R5", 0);
    nav(2'd1, SHIR, "R3");
    shift(32'h00000003, 4, 1, 1, 1, 64'h9, RTI, "R5", 0);
  endtask

  task automatic t_chain;
    logic [DW-1:0] rd; int nt; bit b;
    nav(2'd2, SHDR, "R3");
    shift(32'h16, 5, 0, 0, 1, 64'h0B, SHDR, "R6", 0);
    send(2'd2, '0, 1, 0, 0, 0, 0, rd, nt, b);
    chk(nt == 0, "R8", "no TCK while mid-scan", 64'(nt), 0);
    chk(tap == SHDR, "R8", "tap unchanged", 64'(tap), SHDR);
    chk(rd == '0, "R8", "rdata", 64'(rd), 0);
    shift(32'h5, 3, 1, 1, 1, 64'h2, RTI, "R8", 0);
  endtask

  task automatic t_len1;
    nav(2'd2, SHDR, "R3");
    shift(32'h1, 1, 0, 1, 1, 64'h1, RTI, "R11", 0);
  endtask

  task automatic t_divisor;
    half_div = 8'd3;
    nav(2'd0, RTI, "R2");
    chk(lo_last == 4, "R9", "low phase clocks", 64'(lo_last), 4);
    chk(hi_last == 4, "R9", "high phase clocks", 64'(hi_last), 4);
    half_div = 8'd0;
  endtask

  task automatic t_busy;
    nav(2'd2, SHDR, "R3");
    shift(32'hA5, 8, 0, 1, 1, 64'h5A, RTI, "R10", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state;
    rst_n = 1'b1;
    t_tap_reset;
    t_ir_lsb;
    t_dr_full;
    t_msb_update;
    t_chain;
    t_len1;
    t_divisor;
    t_busy;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule